// File: doc/BRIEF.md
# Linked-Descriptor Frame Fetcher

This block reads a display frame out of memory by following a chain of frame descriptors and presents the frame as a stream of 32-bit words to the display pipeline. A descriptor occupies four consecutive 32-bit words on a 16-byte boundary. In address order these hold the link to the next descriptor, the start address of the frame data, a frame identifier that the block does not use, and a command word. The command word gives a byte count in its low bits and two flags. One flag marks the words as palette data. The other asks for an end-of-frame pulse. When a descriptor links back to itself, the same frame is sent again and again until the block is turned off.

There are two channels. The upper channel (0) is always active. When split-panel mode is on, the lower channel (1) takes every second descriptor, so each half of the panel gets its own list. Software loads each channel's descriptor pointer while the block is stopped, then raises the enable. Afterwards the block moves each pointer forward to the link it has just read. Lowering the enable lets the descriptor in progress complete, and then the block stops.

The memory side is a single read port with a request/grant handshake and in-order read responses. The block never has more reads in flight than its word buffer can hold. A status word records three sticky events: bus errors, and buffer underruns for each channel during a transfer. It is cleared when the block is enabled.

Top module: `fdf_fetcher`

## Requirements
- R1: After reset, px_valid, mem_req and eof_irq are low and stat is zero.
- R2: A descriptor is fetched as four reads at pointer+0, +4, +8 and +12, holding in that order the next link, the source address, an ignored frame ID and the command word. Pointer bits [3:0] are ignored.
- R3: A descriptor streams cmd[20:0]/4 words, reading upward from the source address. Only its final word carries px_last=1.
- R4: A descriptor's words all precede the next descriptor's words, and the stream follows the links. A descriptor that links to itself repeats without end.
- R5: Every word of a descriptor whose cmd bit 26 is set leaves with px_pal=1. Otherwise px_pal=0.
- R6: eof_irq pulses for exactly the cycle in which the last word of a descriptor with cmd bit 21 set is accepted (px_valid and px_ready).
- R7: In split-panel mode (dual=1), descriptors alternate between channel 0 and channel 1, starting with 0, and px_chan tags each word. With dual=0 every word has px_chan=0.
- R8: A pointer write (cfg_we) is taken only while en is low and the block is idle. A write made while the block runs has no effect on the stream.
- R9: A descriptor with a byte count of zero sends no words. The block moves straight on to its link.
- R10: stat bit 5 (channel 0) or bit 4 (channel 1) becomes 1 when px_ready is high and px_valid is low after a word of that channel's descriptor has been accepted but before its last word has. These bits are sticky.
- R11: stat bit 2 becomes 1 on any read response with mem_rerr high and is sticky. All stat bits clear when en rises, and the other stat bits are always 0.
- R12: When en falls, the current descriptor completes and then no further memory requests are made.
- R13: mem_req and mem_addr hold until mem_gnt is seen. Output words hold until px_ready is seen. No word is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable |
| dual | input | 1 | Split-panel mode: alternate channels per descriptor |
| cfg_we | input | 1 | Pointer write strobe |
| cfg_sel | input | 1 | Channel whose pointer is written |
| cfg_ptr | input | 32 | First descriptor address |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Read byte address |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| mem_rerr | input | 1 | Read response carries a bus error |
| px_valid | output | 1 | Output word valid |
| px_ready | input | 1 | Downstream accepts word |
| px_data | output | 32 | Frame word |
| px_chan | output | 1 | Channel of the word (0 upper, 1 lower) |
| px_pal | output | 1 | Word is palette data |
| px_last | output | 1 | Last word of its descriptor |
| eof_irq | output | 1 | End-of-frame pulse |
| stat | output | 16 | Sticky status: bit 2 bus error, bit 4 lower underrun, bit 5 upper underrun |

## Verification
The hardest case to reach is an underrun in the middle of a transfer. With a responsive memory the prefetch buffer never empties between a descriptor's first and last word, so the flag can only be set by starving the read port at exactly that time. The bench watches the output stream. When the first non-final word of the chosen channel is accepted, it holds the grant low for twenty cycles while keeping px_ready high. This empties the buffer in the middle of that channel's transfer, once for the upper channel in single mode and once for the lower channel in split-panel mode. The same runs confirm that the stream carries on afterwards with no word lost.

// File: rtl/fdf_pkg.sv
// Shared constants and the buffered word type for the frame fetcher.
package fdf_pkg;
    localparam int WORD_W    = 32;
    localparam int NCH       = 2;
    localparam int LEN_W     = 21;   // byte count field, cmd[20:0]
    localparam int PAL_BIT   = 26;   // palette flag in the command word
    localparam int EOF_BIT   = 21;   // end-of-frame pulse request
    localparam int STAT_W    = 16;
    localparam int ST_BUSERR = 2;
    localparam int ST_UND_LO = 4;
    localparam int ST_UND_UP = 5;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              chan;
        logic              pal;
        logic              last;
        logic              eofint;
    } fdf_item_t;
endpackage

// File: rtl/fdf_fifo.sv
// Word buffer between memory responses and the output stream.
// Assumes the caller never pushes when full and never pops when empty.
module fdf_fifo #(
    parameter int W     = 36,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH+1);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [LW-1:0] cnt;

    // Storage write, no reset needed.
    always_ff @(posedge clk) begin : store_wr
        if (push) store[wp] <= din;
    end

    // Pointer and occupancy tracking with explicit wrap.
    always_ff @(posedge clk) begin : ptr_upd
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + PW'(1);
            if (pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + PW'(1);
            cnt <= cnt + LW'(push) - LW'(pop);
        end
    end

    assign dout  = store[rp];
    assign empty = (cnt == '0);
    assign level = cnt;
endmodule

// File: rtl/fdf_engine.sv
// Descriptor walker: fetches four-word descriptors, then issues data reads
// within buffer credit and tags each response for the buffer. Assumes
// in-order read responses and byte counts that are multiples of four.
module fdf_engine
    import fdf_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic                       dual,
    input  logic                       cfg_we,
    input  logic                       cfg_sel,
    input  logic [WORD_W-1:0]          cfg_ptr,
    output logic                       mem_req,
    output logic [WORD_W-1:0]          mem_addr,
    input  logic                       mem_gnt,
    input  logic                       mem_rvalid,
    input  logic [WORD_W-1:0]          mem_rdata,
    input  logic [$clog2(DEPTH+1)-1:0] fifo_level,
    output logic                       push,
    output fdf_item_t                  push_item
);
    localparam int LW = $clog2(DEPTH+1);
    localparam int WC = LEN_W - 2;          // word count width
    localparam int PA = WORD_W - 4;         // aligned pointer width

    typedef enum logic [1:0] {ST_IDLE, ST_DESC, ST_DATA} st_t;

    st_t           st;
    logic          ch;
    logic [PA-1:0] dar [NCH];
    logic [2:0]    req_idx, rcv_idx;
    logic [PA-1:0] d_next;
    logic [WORD_W-1:0] d_src;
    logic [LEN_W-1:0]  d_len;
    logic          d_pal, d_eof;
    logic [WC-1:0] issued, received;
    logic [LW-1:0] outstanding;
    logic          grant, credit;
    logic [WC-1:0] len_words;
    logic          unused_bits;

    assign len_words   = d_len[LEN_W-1:2];
    assign credit      = ({1'b0, fifo_level} + {1'b0, outstanding}) < (LW+1)'(DEPTH);
    assign grant       = mem_req && mem_gnt;
    assign unused_bits = ^{cfg_ptr[3:0], d_len[1:0]};

    // Request generation for descriptor words and frame data words.
    always_comb begin : req_gen
        mem_req  = 1'b0;
        mem_addr = '0;
        if (st == ST_DESC && req_idx < 3'd4) begin
            mem_req  = 1'b1;
            mem_addr = {dar[ch], req_idx[1:0], 2'b00};
        end else if (st == ST_DATA && issued < len_words && credit) begin
            mem_req  = 1'b1;
            mem_addr = d_src + WORD_W'({issued, 2'b00});
        end
    end

    // Data responses go to the buffer with their stream tags.
    assign push             = mem_rvalid && (st == ST_DATA);
    assign push_item.data   = mem_rdata;
    assign push_item.chan   = ch;
    assign push_item.pal    = d_pal;
    assign push_item.last   = (received == len_words - WC'(1));
    assign push_item.eofint = d_eof;

    // Sequencer: idle, descriptor fetch, data transfer.
    always_ff @(posedge clk) begin : engine_seq
        if (!rst_n) begin
            st          <= ST_IDLE;
            ch          <= 1'b0;
            req_idx     <= '0;
            rcv_idx     <= '0;
            d_next      <= '0;
            d_src       <= '0;
            d_len       <= '0;
            d_pal       <= 1'b0;
            d_eof       <= 1'b0;
            issued      <= '0;
            received    <= '0;
            outstanding <= '0;
            for (int i = 0; i < NCH; i++) dar[i] <= '0;
        end else begin
            outstanding <= outstanding + LW'(grant) - LW'(mem_rvalid);
            unique case (st)
                ST_IDLE: begin
                    if (en) begin
                        st      <= ST_DESC;
                        ch      <= 1'b0;
                        req_idx <= '0;
                        rcv_idx <= '0;
                    end else if (cfg_we) begin
                        dar[cfg_sel] <= cfg_ptr[WORD_W-1:4];
                    end
                end
                ST_DESC: begin
                    if (grant) req_idx <= req_idx + 3'd1;
                    if (mem_rvalid) begin
                        rcv_idx <= rcv_idx + 3'd1;
                        case (rcv_idx)
                            3'd0: d_next <= mem_rdata[WORD_W-1:4];
                            3'd1: d_src  <= mem_rdata;
                            3'd3: begin
                                d_len    <= mem_rdata[LEN_W-1:0];
                                d_pal    <= mem_rdata[PAL_BIT];
                                d_eof    <= mem_rdata[EOF_BIT];
                                issued   <= '0;
                                received <= '0;
                                dar[ch]  <= d_next;
                                st       <= ST_DATA;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_DATA: begin
                    if (grant)      issued   <= issued + WC'(1);
                    if (mem_rvalid) received <= received + WC'(1);
                    if (issued == len_words && outstanding == '0) begin
                        if (!en) begin
                            st <= ST_IDLE;
                        end else begin
                            st      <= ST_DESC;
                            ch      <= dual ? ~ch : 1'b0;
                            req_idx <= '0;
                            rcv_idx <= '0;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fdf_status.sv
// Sticky status: bus error and per-channel underrun in the middle of a
// transfer. Everything clears on the cycle the enable rises.
module fdf_status
    import fdf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              mem_rvalid,
    input  logic              mem_rerr,
    input  logic              pop,
    input  logic              pop_last,
    input  logic              pop_chan,
    input  logic              px_ready,
    input  logic              px_valid,
    output logic [STAT_W-1:0] stat
);
    logic en_q, mid, mid_ch, buserr, und_lo, und_up;

    // Track transfer progress at the output and record events.
    always_ff @(posedge clk) begin : stat_upd
        if (!rst_n) begin
            en_q <= 1'b0; mid <= 1'b0; mid_ch <= 1'b0;
            buserr <= 1'b0; und_lo <= 1'b0; und_up <= 1'b0;
        end else begin
            en_q <= en;
            if (en && !en_q) begin
                mid <= 1'b0; buserr <= 1'b0; und_lo <= 1'b0; und_up <= 1'b0;
            end else begin
                if (mem_rvalid && mem_rerr) buserr <= 1'b1;
                if (pop) begin
                    mid    <= !pop_last;
                    mid_ch <= pop_chan;
                end
                if (mid && px_ready && !px_valid) begin
                    if (mid_ch) und_lo <= 1'b1;
                    else        und_up <= 1'b1;
                end
            end
        end
    end

    // Assemble the status word.
    always_comb begin : stat_pack
        stat            = '0;
        stat[ST_BUSERR] = buserr;
        stat[ST_UND_LO] = und_lo;
        stat[ST_UND_UP] = und_up;
    end
endmodule

// File: rtl/fdf_fetcher.sv
// Top level: descriptor walker, word buffer and status tracker.
// Assumes pointers are loaded while en is low and that memory answers
// reads in order.
module fdf_fetcher
    import fdf_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              dual,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [WORD_W-1:0] cfg_ptr,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_rerr,
    output logic              px_valid,
    input  logic              px_ready,
    output logic [WORD_W-1:0] px_data,
    output logic              px_chan,
    output logic              px_pal,
    output logic              px_last,
    output logic              eof_irq,
    output logic [STAT_W-1:0] stat
);
    localparam int LW = $clog2(DEPTH+1);
    localparam int IW = $bits(fdf_item_t);

    logic          fifo_push, fifo_pop, fifo_empty;
    logic [LW-1:0] fifo_level;
    fdf_item_t     in_item, head;

    fdf_engine #(.DEPTH(DEPTH)) u_engine (
        .clk(clk), .rst_n(rst_n), .en(en), .dual(dual),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_ptr(cfg_ptr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .fifo_level(fifo_level), .push(fifo_push), .push_item(in_item)
    );

    fdf_fifo #(.W(IW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(fifo_push), .din(in_item),
        .pop(fifo_pop), .dout(head), .empty(fifo_empty), .level(fifo_level)
    );

    fdf_status u_status (
        .clk(clk), .rst_n(rst_n), .en(en), .mem_rvalid(mem_rvalid),
        .mem_rerr(mem_rerr), .pop(fifo_pop), .pop_last(head.last),
        .pop_chan(head.chan), .px_ready(px_ready), .px_valid(px_valid),
        .stat(stat)
    );

    // Output stream taken straight from the buffer head.
    assign px_valid = !fifo_empty;
    assign fifo_pop = px_valid && px_ready;
    assign px_data  = head.data;
    assign px_chan  = head.chan;
    assign px_pal   = head.pal;
    assign px_last  = head.last;
    assign eof_irq  = fifo_pop && head.last && head.eofint;
endmodule

// File: rtl/fdf_checker.sv
// Protocol and status properties for fdf_fetcher, attached by bind.
module fdf_checker
    import fdf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LW    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              mem_req,
    input logic              mem_gnt,
    input logic [WORD_W-1:0] mem_addr,
    input logic              px_valid,
    input logic              px_ready,
    input logic [WORD_W-1:0] px_data,
    input logic              px_chan,
    input logic              px_pal,
    input logic              px_last,
    input logic              eof_irq,
    input logic [STAT_W-1:0] stat,
    input logic              fifo_push,
    input logic [LW-1:0]     fifo_level
);
    // R13
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));

    // R13
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid && !px_ready |=> px_valid && $stable(px_data) &&
        $stable(px_chan) && $stable(px_pal) && $stable(px_last));

    // R6
    irq_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eof_irq |-> px_valid && px_ready && px_last);

    // R11
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |=> stat == '0);

    // R13
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> fifo_level < LW'(DEPTH));
endmodule

bind fdf_fetcher fdf_checker #(.DEPTH(DEPTH), .LW(LW)) chk_i (
    .clk(clk), .rst_n(rst_n), .en(en), .mem_req(mem_req), .mem_gnt(mem_gnt),
    .mem_addr(mem_addr), .px_valid(px_valid), .px_ready(px_ready),
    .px_data(px_data), .px_chan(px_chan), .px_pal(px_pal), .px_last(px_last),
    .eof_irq(eof_irq), .stat(stat), .fifo_push(fifo_push),
    .fifo_level(fifo_level)
);

// File: tb/fdf_fetcher_tb_top.sv
// Bench: memory model with grant throttling, output collector, and an
// expected stream computed by walking the descriptor lists in bench memory.
module fdf_fetcher_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LAT = 2;

    logic        clk = 1'b0, rst_n = 1'b0, en = 1'b0, dual = 1'b0;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [31:0] cfg_ptr = '0;
    logic        mem_req, mem_gnt = 1'b1, mem_rvalid = 1'b0, mem_rerr = 1'b0;
    logic [31:0] mem_addr, mem_rdata = '0;
    logic        px_valid, px_ready = 1'b1, px_chan, px_pal, px_last, eof_irq;
    logic [31:0] px_data;
    logic [15:0] stat;

    fdf_fetcher dut_i (.*);

    initial forever #2.5 clk = ~clk;

    logic [31:0] mem [256];
    int errors = 0, checks = 0, cyc = 0;
    bit rdy_toggle = 0, err_en = 0, blk_arm = 0, blk_ch = 0;
    int blk_cnt = 0;
    logic [31:0] err_addr = '0;
    logic        p_v [LAT];
    logic [31:0] p_a [LAT];
    logic [31:0] rx_data [256];
    bit rx_chan [256], rx_pal [256], rx_last [256];
    int rx_n = 0, irq_n = 0, g_n = 0;
    logic [31:0] g_log [64];
    logic [31:0] ex_data [256];
    bit ex_chan [256], ex_pal [256], ex_last [256], ex_eof [256];
    int ex_n = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Negedge responder: set controls, then settle and observe handshakes.
    initial begin
        for (int i = 0; i < LAT; i++) begin p_v[i] = 1'b0; p_a[i] = '0; end
        forever begin
            @(negedge clk);
            cyc++;
            px_ready = rdy_toggle ? (cyc % 3 != 0) : 1'b1;
            if (blk_cnt > 0) begin mem_gnt = 1'b0; blk_cnt--; end
            else mem_gnt = 1'b1;
            #1;
            if (px_valid && px_ready && rx_n < 256) begin
                rx_data[rx_n] = px_data; rx_chan[rx_n] = px_chan;
                rx_pal[rx_n] = px_pal;   rx_last[rx_n] = px_last;
                rx_n++;
                if (eof_irq) irq_n++;
                if (blk_arm && px_chan == blk_ch && !px_last) begin
                    blk_cnt = 20; blk_arm = 0;
                end
            end
            for (int i = LAT-1; i > 0; i--) begin p_v[i] = p_v[i-1]; p_a[i] = p_a[i-1]; end
            p_v[0] = mem_req && mem_gnt;
            p_a[0] = mem_addr;
            if (mem_req && mem_gnt && g_n < 64) begin g_log[g_n] = mem_addr; g_n++; end
            mem_rvalid = p_v[LAT-1];
            mem_rdata  = mem[p_a[LAT-1][9:2]];
            mem_rerr   = p_v[LAT-1] && err_en && (p_a[LAT-1] == err_addr);
        end
    end

    task automatic set_desc(input int a, input int nxt, input int src, input logic [31:0] cmd);
        mem[a/4] = nxt; mem[a/4+1] = src; mem[a/4+2] = 32'hF00 + a; mem[a/4+3] = cmd;
    endtask

    task automatic cfg_write(input bit sel, input logic [31:0] ptr);
        @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_ptr = ptr;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    // Walk the lists as the requirements describe to build the expected stream.
    task automatic gen_expect(input logic [31:0] p0, input logic [31:0] p1,
                              input bit dl, input int n);
        logic [31:0] cur [2];
        int ch = 0, guard = 0;
        cur[0] = p0 & ~32'hF; cur[1] = p1 & ~32'hF; ex_n = 0;
        while (ex_n < n && guard < 1000) begin
            int b, nw;
            logic [31:0] nx, src, cmd;
            b = cur[ch] >> 2; nx = mem[b]; src = mem[b+1]; cmd = mem[b+3];
            nw = int'(cmd[20:0]) / 4;
            for (int i = 0; i < nw && ex_n < n; i++) begin
                ex_data[ex_n] = mem[(src>>2)+i]; ex_chan[ex_n] = ch[0];
                ex_pal[ex_n] = cmd[26]; ex_last[ex_n] = (i == nw-1);
                ex_eof[ex_n] = cmd[21]; ex_n++;
            end
            cur[ch] = nx & ~32'hF;
            if (dl) ch = 1 - ch;
            guard++;
        end
    endtask

    task automatic compare(input logic [31:0] p0, input logic [31:0] p1, input bit dl);
        int bd = 0, bc = 0, bp = 0, bl = 0, ei = 0, fd = -1;
        gen_expect(p0, p1, dl, rx_n);
        for (int k = 0; k < rx_n; k++) begin
            if (rx_data[k] !== ex_data[k]) begin bd++; if (fd < 0) fd = k; end
            if (rx_chan[k] != ex_chan[k]) bc++;
            if (rx_pal[k] != ex_pal[k]) bp++;
            if (rx_last[k] != ex_last[k]) bl++;
            if (ex_last[k] && ex_eof[k]) ei++;
        end
        check(bd == 0, "R3 R4 R13", "data mismatches", bd, 0);
        if (fd >= 0) check(1'b0, "R3 R4", "first bad word", rx_data[fd], ex_data[fd]);
        check(bc == 0, "R7", "channel tag mismatches", bc, 0);
        check(bp == 0, "R5", "palette flag mismatches", bp, 0);
        check(bl == 0, "R3", "last flag mismatches", bl, 0);
        check(irq_n == ei, "R6", "eof pulses", irq_n, ei);
    endtask

    // One run: load pointers, enable, collect, write while busy, stop, drain.
    task automatic run(input logic [31:0] p0, input logic [31:0] p1, input bit dl,
                       input int n, input bit arm, input bit ach);
        int t = 0;
        cfg_write(1'b0, p0); cfg_write(1'b1, p1);
        dual = dl; rx_n = 0; irq_n = 0; g_n = 0; blk_ach_set(arm, ach);
        @(negedge clk); en = 1'b1;
        @(negedge clk); #1;
        check(stat == 16'h0, "R11", "stat after enable", stat, 0);
        while (rx_n < n && t < 4000) begin @(negedge clk); t++; end
        check(rx_n >= n, "R4", "words received", rx_n, n);
        cfg_write(1'b0, 32'h220);   // R8: must be ignored while running
        @(negedge clk); en = 1'b0;
        repeat (150) @(negedge clk);
        #1;
        check(!mem_req && !px_valid, "R12", "quiet after disable", {mem_req, px_valid}, 0);
        check(rx_n > 0 && rx_last[rx_n-1], "R12", "stop on descriptor end", rx_n, 0);
        compare(p0, p1, dl);
    endtask

    task automatic blk_ach_set(input bit arm, input bit ach);
        blk_arm = arm; blk_ch = ach;
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 32'h1000_0000 + i * 32'h0001_0003;
        for (int i = 128; i < 256; i++) mem[i] = '0;
        set_desc(32'h200, 32'h200, 32'h040, 32'h0020_0018);  // self, 6 words, eof
        set_desc(32'h220, 32'h240, 32'h080, 32'h0000_000C);  // 3 words
        set_desc(32'h240, 32'h260, 32'h0C0, 32'h0420_0014);  // 5 words, palette, eof
        set_desc(32'h260, 32'h220, 32'h000, 32'h0000_0000);  // zero length (R9)
        set_desc(32'h280, 32'h280, 32'h100, 32'h0020_0020);  // upper half
        set_desc(32'h290, 32'h290, 32'h120, 32'h0000_0020);  // lower half
        set_desc(32'h2A0, 32'h2A0, 32'h000, 32'h0000_0040);  // 16 words
        set_desc(32'h2B0, 32'h2B0, 32'h100, 32'h0000_0040);  // 16 words

        repeat (4) @(negedge clk);
        #1;
        // R1: reset state
        check(!px_valid, "R1", "px_valid in reset", px_valid, 0);
        check(!mem_req, "R1", "mem_req in reset", mem_req, 0);
        check(stat == 16'h0, "R1", "stat in reset", stat, 0);
        check(!eof_irq, "R1", "eof_irq in reset", eof_irq, 0);
        @(negedge clk); rst_n = 1'b1;

        // Self-linked frame, unaligned pointer (R2, R3, R4, R6, R8, R12)
        run(32'h207, 32'h0, 1'b0, 15, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++)
            check(g_log[i] == 32'h200 + 4*i, "R2", "descriptor read address", g_log[i], 32'h200 + 4*i);
        check(stat == 16'h0, "R10", "no underrun on clean run", stat, 0);

        // Chain with palette and zero-length descriptor, slow consumer (R4, R5, R9, R13)
        rdy_toggle = 1;
        run(32'h220, 32'h0, 1'b0, 30, 1'b0, 1'b0);
        rdy_toggle = 0;

        // Split panel (R7)
        run(32'h280, 32'h290, 1'b1, 40, 1'b0, 1'b0);

        // Upper channel underrun by starving the read port (R10)
        run(32'h2A0, 32'h0, 1'b0, 40, 1'b1, 1'b0);
        check(stat[5] == 1'b1, "R10", "upper underrun bit5", stat[5], 1);
        check(stat[4] == 1'b0, "R10", "lower underrun bit4 in single mode", stat[4], 0);

        // Lower channel underrun in split mode (R10)
        run(32'h2A0, 32'h2B0, 1'b1, 40, 1'b1, 1'b1);
        check(stat[4] == 1'b1, "R10", "lower underrun bit4", stat[4], 1);

        // Bus error on a data word (R11)
        err_en = 1; err_addr = 32'h048;
        run(32'h200, 32'h0, 1'b0, 12, 1'b0, 1'b0);
        check(stat[2] == 1'b1, "R11", "bus error bit2", stat[2], 1);
        check((stat & ~16'h0034) == 16'h0, "R11", "reserved stat bits", stat, stat & 16'h0034);
        err_en = 0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule